// File: doc/BRIEF.md
# External Interrupt Request Latch

This block merges one dedicated interrupt pin and a set of general-purpose port pins into a single pending external interrupt for a small 8-bit processor. Each port pin is included only when its own enable bit is set. The dedicated pin is always included. All contributing lines are ORed together, and the result feeds a detector. The detector works in one of two trigger policies.

- **Edge-only:** a request is latched only on a 0-to-1 transition of the merged signal.
- **Edge-plus-level:** a request is latched on a rising edge, and is also re-latched every cycle while the merged signal stays high. This lets several wired-OR sources share the line, and service keeps repeating until every source has let go.

The processor clears the latch with a one-cycle acknowledge pulse. Its global interrupt mask hides the request without discarding it.

A port pin configured as an output still counts as a source. Its level is then taken from the value the port drives, not from the pad. Every pad input passes through a two-flop synchroniser before it is used. A separate status output gives the synchronised level of the dedicated pin alone, for branch-on-pin-level instructions. This output never includes the port sources.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, `irq_pending`, `irq_req` and `pin_status` are 0. All port enables are 0, so a high port pad raises no request. The trigger policy is edge-only.
- R2: A 0-to-1 transition on the dedicated pin sets `irq_pending`. The set is visible three clock edges after the pad changes: two synchroniser stages, then the latch.
- R3: In edge-only mode (`cfg_trig_level`=0), a merged signal that stays high after an acknowledge does not set the latch again. A new request needs the merged signal to fall to 0 and rise again.
- R4: In edge-plus-level mode (`cfg_trig_level`=1), a high merged signal sets the latch. If the merged signal is still high when an acknowledge clears the latch, the latch sets again on the following edge.
- R5: Port pin i contributes to the OR only when bit i of the enable register is 1. A disabled pin contributes 0.
- R6: When `port_dir[i]`=1 (output), pin i's level is `port_drv[i]` and `port_pad[i]` is ignored. When `port_dir[i]`=0 (input), the level is `port_pad[i]`.
- R7: `pin_status` equals the dedicated pad delayed by the two synchroniser stages. It is never affected by any port pin.
- R8: `irq_req` is 0 whenever `cpu_mask`=1. A request pending under the mask stays in the latch and appears on `irq_req` once the mask clears.
- R9: An acknowledge clears the latch at the next edge. It wins over a set arriving in the same cycle.
- R10: A cycle with `cfg_wr`=1 loads `cfg_pin_en` into the enable register and `cfg_trig_level` into the mode bit at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pad | input | 1 | Dedicated interrupt pin, active high, asynchronous |
| port_pad | input | 4 | Port pad levels, asynchronous |
| port_drv | input | 4 | Values the port drives on pins set as outputs |
| port_dir | input | 4 | Pin direction, 1 = output |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pin_en | input | 4 | New per-pin enable bits |
| cfg_trig_level | input | 1 | New trigger policy, 1 = edge-plus-level |
| cpu_mask | input | 1 | Processor global interrupt mask |
| irq_ack | input | 1 | One-cycle acknowledge, clears the latch |
| irq_pending | output | 1 | Latched request |
| irq_req | output | 1 | Request to the processor, masked |
| pin_status | output | 1 | Synchronised dedicated-pin level |

## Verification
The assertions assume that `irq_ack` is a single-cycle pulse and that configuration changes arrive only through `cfg_wr`. They also assume the trigger policy is not switched in the cycle just before the latch rises.

The stimulus meets these assumptions. Every input is driven on the falling edge. Acknowledges are one cycle wide, and configuration is written only while the merged signal is quiet. The single exception is the deliberate collision case, where an acknowledge is timed onto the same edge as a fresh rising edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;

  // Level seen on a port pin: driven value when output, pad when input.
  function automatic logic pin_level(input logic is_out, input logic pad, input logic drv);
    return is_out ? drv : pad;
  endfunction

  // Condition that sets the pending latch this cycle.
  function automatic logic latch_set(input trig_mode_e mode, input logic now_v, input logic prev_v);
    logic rise;
    rise = now_v & ~prev_v;
    return rise | ((mode == TRIG_EDGE_LEVEL) & now_v);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  generate
    if (STAGES >= 2) begin : g_chk
      AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(chain[STAGES-2])); // R7
    end
  endgenerate

endmodule

// File: rtl/irq_source_merge.sv
module irq_source_merge
  import ext_irq_pkg::*;
#(
  parameter int N_PORT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PORT-1:0] port_pad,
  input  logic [N_PORT-1:0] port_drv,
  input  logic [N_PORT-1:0] port_dir,
  input  logic [N_PORT-1:0] pin_en,
  input  logic              irq_s,
  input  logic [N_PORT-1:0] port_s,
  output logic [N_PORT-1:0] port_lvl,
  output logic              merged
);
  logic [N_PORT-1:0] gated;

  genvar i;
  generate
    for (i = 0; i < N_PORT; i++) begin : g_pin
      assign port_lvl[i] = pin_level(port_dir[i], port_pad[i], port_drv[i]);
      assign gated[i]    = port_s[i] & pin_en[i];
    end
  endgenerate

  assign merged = irq_s | (|gated);

  AST_DISABLED_PINS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en == '0) |-> (merged == irq_s)); // R5

endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       merged,
  input  logic       ack,
  output logic       pending,
  output logic       rise
);
  logic merged_q;
  logic set_now;

  assign rise    = merged & ~merged_q;
  assign set_now = latch_set(mode, merged, merged_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merged_q <= 1'b0;
      pending  <= 1'b0;
    end else begin
      merged_q <= merged;
      if (ack)          pending <= 1'b0;
      else if (set_now) pending <= 1'b1;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !pending); // R9
  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !ack) |=> pending); // R2
  AST_LEVEL_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE_LEVEL && merged && !ack) |=> pending); // R4
  AST_EDGE_ONLY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pending) && $past(mode) == TRIG_EDGE) |-> $past(rise)); // R3

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int N_PORT      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pad,
  input  logic [N_PORT-1:0] port_pad,
  input  logic [N_PORT-1:0] port_drv,
  input  logic [N_PORT-1:0] port_dir,
  input  logic              cfg_wr,
  input  logic [N_PORT-1:0] cfg_pin_en,
  input  logic              cfg_trig_level,
  input  logic              cpu_mask,
  input  logic              irq_ack,
  output logic              irq_pending,
  output logic              irq_req,
  output logic              pin_status
);
  localparam int SW = N_PORT + 1;

  logic [N_PORT-1:0] pin_en_q;
  trig_mode_e        mode_q;
  logic [N_PORT-1:0] port_lvl;
  logic [SW-1:0]     sync_q;
  logic              merged;
  logic              edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en_q <= '0;
      mode_q   <= TRIG_EDGE;
    end else if (cfg_wr) begin
      pin_en_q <= cfg_pin_en;
      mode_q   <= trig_mode_e'(cfg_trig_level);
    end
  end

  irq_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({port_lvl, irq_pad}),
    .q     (sync_q)
  );

  irq_source_merge #(.N_PORT(N_PORT)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_pad (port_pad),
    .port_drv (port_drv),
    .port_dir (port_dir),
    .pin_en   (pin_en_q),
    .irq_s    (sync_q[0]),
    .port_s   (sync_q[SW-1:1]),
    .port_lvl (port_lvl),
    .merged   (merged)
  );

  irq_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .merged  (merged),
    .ack     (irq_ack),
    .pending (irq_pending),
    .rise    (edge_seen)
  );

  assign irq_req    = irq_pending & ~cpu_mask;
  assign pin_status = sync_q[0];

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mask |-> !irq_req); // R8
  AST_REQ_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_pending); // R8
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (pin_en_q == $past(cfg_pin_en))); // R10

endmodule

// File: tb/ext_irq_latch_test.sv
`timescale 1ns/1ps
module ext_irq_latch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_pad = 1'b0;
  logic [3:0] port_pad = '0, port_drv = '0, port_dir = '0, cfg_pin_en = '0;
  logic cfg_wr = 1'b0, cfg_trig_level = 1'b0, cpu_mask = 1'b0, irq_ack = 1'b0;
  logic irq_pending, irq_req, pin_status;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_latch uut (.*);

  // {irq, port[3:0], ack, mask, exp_pending, exp_req, exp_status}, edge-only, all pins enabled
  localparam logic [9:0] VEC [13] = '{
    10'b0_0000_0_0_000,  // idle
    10'b1_0000_0_0_111,  // R2 dedicated edge
    10'b1_0000_1_0_001,  // R3 held high, ack, no relatch
    10'b0_0000_0_0_000,
    10'b0_0001_0_0_110,  // R5 port edge; R7 status ignores port
    10'b0_0001_0_1_100,  // R8 masked stays pending
    10'b0_0001_0_0_110,  // R8 delivered after unmask
    10'b0_0001_1_0_000,  // R3 ack, still high
    10'b0_0011_0_0_000,  // R3 merged already high, no new edge
    10'b0_0000_0_0_000,
    10'b1_1000_0_0_111,  // R3 new rise after fall
    10'b1_1000_1_0_001,
    10'b0_0000_0_0_000
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic cfg(input logic [3:0] en, input logic lvl);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_pin_en = en; cfg_trig_level = lvl;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: port pads high but enables reset to 0
    port_pad = 4'hF;
    repeat (4) @(negedge clk);
    check("R1 pending", irq_pending, 1'b0);
    check("R1 req", irq_req, 1'b0);
    check("R1 status", pin_status, 1'b0);
    port_pad = 4'h0;
    repeat (3) @(negedge clk);
    cfg(4'hF, 1'b0);  // R10

    foreach (VEC[k]) begin
      @(negedge clk);
      irq_pad = VEC[k][9]; port_pad = VEC[k][8:5];
      irq_ack = VEC[k][4]; cpu_mask = VEC[k][3];
      @(negedge clk) irq_ack = 1'b0;
      repeat (3) @(negedge clk);
      check($sformatf("R2/R3 vec%0d pending", k), irq_pending, VEC[k][2]);
      check($sformatf("R8 vec%0d req", k), irq_req, VEC[k][1]);
      check($sformatf("R7 vec%0d status", k), pin_status, VEC[k][0]);
    end

    // R7 latency: two stages
    @(negedge clk) irq_pad = 1'b1;
    @(negedge clk) check("R7 status after 1 edge", pin_status, 1'b0);
    @(negedge clk) check("R7 status after 2 edges", pin_status, 1'b1);
    @(negedge clk) check("R2 pending after 3 edges", irq_pending, 1'b1);
    irq_pad = 1'b0; ack_pulse();
    repeat (3) @(negedge clk);

    // R9: ack lands on the edge where the rise would latch
    @(negedge clk) irq_pad = 1'b1;
    @(negedge clk);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    check("R9 ack beats set", irq_pending, 1'b0);
    repeat (3) @(negedge clk);
    check("R9/R3 no later relatch", irq_pending, 1'b0);
    irq_pad = 1'b0;
    repeat (3) @(negedge clk);

    // R5: disabled pin ignored
    cfg(4'b0001, 1'b0);
    port_pad = 4'b0100;
    repeat (4) @(negedge clk);
    check("R5 disabled pin", irq_pending, 1'b0);
    port_pad = 4'h0;

    // R6: output pin uses driven value
    cfg(4'b0010, 1'b0);
    port_dir = 4'b0010; port_pad = 4'b0010; port_drv = 4'b0000;
    repeat (4) @(negedge clk);
    check("R6 pad ignored when output", irq_pending, 1'b0);
    port_drv = 4'b0010;
    repeat (4) @(negedge clk);
    check("R6 driven value raises", irq_pending, 1'b1);
    port_drv = 4'b0000; port_pad = 4'b0000; port_dir = 4'b0000;
    ack_pulse();
    repeat (3) @(negedge clk);

    // R4: level mode
    cfg(4'b0001, 1'b1);
    port_pad = 4'b0001;
    repeat (3) @(negedge clk);
    check("R4 level latches", irq_pending, 1'b1);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    check("R4 cleared by ack", irq_pending, 1'b0);
    @(negedge clk) check("R4 relatched while high", irq_pending, 1'b1);
    port_pad = 4'b0000;
    repeat (3) @(negedge clk);
    ack_pulse();
    repeat (2) @(negedge clk);
    check("R4 stays clear after release", irq_pending, 1'b0);

    finish_up();
  end
endmodule